// File: doc/BRIEF.md
# GPIO Port Pin-Interrupt Unit

This block holds the interrupt logic for one GPIO port of eight pins. Each pin has an interrupt enable bit and a two-bit trigger selection. The selection can pick: no trigger, a low level, a high level, or a mismatch against a reference level. Pin levels first pass through a two-flop synchroniser. A pulse on the data-read strobe copies the synchronised levels into a reference register, and the mismatch selection compares against that register.

Every pin drives an active-low request. The requests are combined as an open-drain wired-OR, modelled here as an AND of the active-low lines, into one shared port interrupt line. There is no pending flag anywhere in the unit:

- A request asserts as soon as its enable and trigger condition both hold.
- A request releases as soon as either of them stops holding.

The line therefore behaves like an edge when it asserts and like a level when it releases. Software finds the source by polling a status vector that shows which pins are asserting. The configuration registers are byte-wide. They are written through an address/strobe port and can be read back through a combinational read port.

Top module: `port_pin_irq`

## Requirements
- R1: After reset the line `irq_n` is 1, `irq_src` is 0, the enable and both mode registers read 0, and the reference register is 0.
- R2: A write with `wr_en`=1 loads `wr_data` on the clock edge. Address 1 is the enable register, address 2 holds mode bit 0 of every pin, and address 3 holds mode bit 1. Reading an address returns that register. A write to address 0 changes nothing.
- R3: A pin with mode {bit1,bit0}=00 never asserts, whatever its level or enable.
- R4: A pin with mode 01 and its enable set asserts while its synchronised level is 0.
- R5: A pin with mode 10 and its enable set asserts while its synchronised level is 1.
- R6: A pin with mode 11 and its enable set asserts while its synchronised level differs from its reference bit. A `data_rd` pulse loads the synchronised levels into the reference on that clock edge, which releases such a pin.
- R7: A pin whose enable is 0 never asserts. Setting the enable while the condition already holds asserts the pin right after that write edge. Clearing the enable releases it after that edge.
- R8: `irq_n` is 0 exactly when some bit of `irq_src` is 1. If a second pin asserts while a first pin is asserting, releasing the first leaves `irq_n` low with no rising edge.
- R9: A change on `pin_in` reaches the trigger logic after two rising clock edges, not after one.
- R10: Reading address 0 returns the synchronised pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 8 | Raw pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| data_rd | input | 1 | Data-register read strobe; loads the reference |
| irq_src | output | 8 | Pins currently asserting |
| irq_n | output | 1 | Shared active-low port interrupt line |

## Verification
The hardest case to reach is the hand-over on the shared line. One pin must already be holding `irq_n` low when a second pin qualifies, and then the first must release while the second keeps the line low. Random stimulus rarely lines this up. A directed sequence therefore builds it with two pins in opposite level modes and clears the first pin's enable, while a monitor counts any rising edge of the line. The mismatch mode needs a reference that differs from the pin, so the data-read strobe is pulsed at chosen moments between pin changes. Random strobes in the random phase exercise it further.

// File: rtl/port_pin_irq.sv
module port_pin_irq #(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [NPINS-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [NPINS-1:0] rd_data,
  input  logic             data_rd,
  output logic [NPINS-1:0] irq_src,
  output logic             irq_n
);
  localparam logic [1:0] A_PIN = 2'd0;
  localparam logic [1:0] A_EN  = 2'd1;
  localparam logic [1:0] A_M0  = 2'd2;
  localparam logic [1:0] A_M1  = 2'd3;

  logic [NPINS-1:0] sync_q [SYNC_STAGES];
  logic [NPINS-1:0] pin_s, en_q, m0_q, m1_q, ref_q, hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
    end
  end
  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      m0_q  <= '0;
      m1_q  <= '0;
      ref_q <= '0;
    end else begin
      if (wr_en && wr_addr == A_EN) en_q <= wr_data;
      if (wr_en && wr_addr == A_M0) m0_q <= wr_data;
      if (wr_en && wr_addr == A_M1) m1_q <= wr_data;
      if (data_rd) ref_q <= pin_s;
    end
  end

  always_comb begin
    case (rd_addr)
      A_PIN:   rd_data = pin_s;
      A_EN:    rd_data = en_q;
      A_M0:    rd_data = m0_q;
      default: rd_data = m1_q;
    endcase
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_comb begin
      case ({m1_q[i], m0_q[i]})
        2'b01:   hit[i] = ~pin_s[i];
        2'b10:   hit[i] = pin_s[i];
        2'b11:   hit[i] = pin_s[i] ^ ref_q[i];
        default: hit[i] = 1'b0;
      endcase
    end

    p_off_mode_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ({m1_q[i], m0_q[i]} == 2'b00) |-> !irq_src[i]);
    p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[i] |-> !irq_src[i]);
  end

  assign irq_src = en_q & hit;
  assign irq_n   = ~|irq_src;

  p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_EN) |=> en_q == $past(wr_data));
  p_ref_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && rst_n) |=> ref_q == $past(pin_s));
  p_line_vs_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> irq_src != '0);
  p_sync_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(pin_s) |-> $past(rst_n) && $changed($past(sync_q[0])));
endmodule

// File: tb/port_pin_irq_test.sv
module port_pin_irq_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] pin_in = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic data_rd = 0;
  logic [7:0] rd_data, irq_src;
  logic irq_n;
  int total = 0, bad = 0, rises = 0;

  always #2.5 clk = ~clk;

  port_pin_irq #(.NPINS(8), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .data_rd(data_rd), .irq_src(irq_src), .irq_n(irq_n));

  // independent reference model
  logic [7:0] m_s1, m_s, m_en, m_m0, m_m1, m_ref;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s <= 0; m_en <= 0; m_m0 <= 0; m_m1 <= 0; m_ref <= 0;
    end else begin
      m_s1 <= pin_in; m_s <= m_s1;
      if (wr_en && wr_addr == 2'd1) m_en <= wr_data;
      if (wr_en && wr_addr == 2'd2) m_m0 <= wr_data;
      if (wr_en && wr_addr == 2'd3) m_m1 <= wr_data;
      if (data_rd) m_ref <= m_s;
    end
  end

  always @(posedge irq_n) rises++;

  function automatic logic [7:0] exp_src();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      case ({m_m1[i], m_m0[i]})
        2'b01: r[i] = ~m_s[i];
        2'b10: r[i] = m_s[i];
        2'b11: r[i] = m_s[i] ^ m_ref[i];
        default: r[i] = 1'b0;
      endcase
    end
    return r & m_en;
  endfunction

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return m_s;
      2'd1: return m_en;
      2'd2: return m_m0;
      default: return m_m1;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic model_check();
    chk("R3,R4,R5,R6,R7 src", irq_src, exp_src());
    chk("R8 line", {7'd0, irq_n}, {7'd0, ~|exp_src()});
    chk("R2,R10 readback", rd_data, exp_rd(rd_addr));
  endtask

  initial begin
    #(5ns * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r0;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    data_rd = 1;              // strobe held during reset must not matter
    repeat (2) @(negedge clk);
    rst_n = 1; data_rd = 0;
    // R1 reset state
    chk("R1 line", {7'd0, irq_n}, 8'h01);
    chk("R1 src", irq_src, 8'h00);
    for (int a = 1; a < 4; a++) begin
      rd_addr = a[1:0]; #1;
      chk("R1 regs", rd_data, 8'h00);
    end
    // R9 sync delay with pin0 in high mode (10)
    wr(2'd1, 8'h01); wr(2'd3, 8'h01);
    chk("R5 idle", irq_src, 8'h00);
    pin_in = 8'h01;
    tick();
    chk("R9 one edge", {7'd0, irq_n}, 8'h01);
    tick();
    chk("R9 two edges", {7'd0, irq_n}, 8'h00);
    chk("R5 high asserts", irq_src, 8'h01);
    rd_addr = 2'd0; #1;
    chk("R10 pin level", rd_data, 8'h01);
    // R8 hand-over: pin1 low mode (01)
    wr(2'd2, 8'h02); wr(2'd1, 8'h03);
    chk("R4 low asserts", irq_src, 8'h03);
    r0 = rises;
    wr(2'd1, 8'h02);
    chk("R7 clear releases", irq_src, 8'h02);
    chk("R8 line held", {7'd0, irq_n}, 8'h00);
    chk("R8 no rise", 8'(rises - r0), 8'h00);
    // R6 mismatch mode on pin2
    wr(2'd1, 8'h00);
    pin_in = 8'h04; tick(); tick();
    wr(2'd2, 8'h04); wr(2'd3, 8'h04);
    chk("R7 disabled quiet", irq_src, 8'h00);
    wr(2'd1, 8'h04);
    chk("R7 enable asserts now", irq_src, 8'h04);
    data_rd = 1; tick(); data_rd = 0;
    chk("R6 read releases", irq_src, 8'h00);
    pin_in = 8'h00; tick(); tick();
    chk("R6 change asserts", irq_src, 8'h04);
    // R3 off mode
    wr(2'd2, 8'h00); wr(2'd3, 8'h00); wr(2'd1, 8'hFF);
    pin_in = 8'hA5; tick(); tick();
    chk("R3 off mode", irq_src, 8'h00);
    chk("R3 line", {7'd0, irq_n}, 8'h01);
    // R2 address 0 write ignored
    wr(2'd0, 8'h3C);
    for (int a = 1; a < 4; a++) begin
      rd_addr = a[1:0]; #1;
      chk("R2 addr0 ignored", rd_data, exp_rd(a[1:0]));
    end
    chk("R2 en kept", exp_rd(2'd1), 8'hFF);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 3) == 0) pin_in = 8'($urandom);
      wr_en = ($urandom_range(0, 4) == 0);
      wr_addr = 2'($urandom); wr_data = 8'($urandom);
      data_rd = ($urandom_range(0, 5) == 0);
      rd_addr = 2'($urandom);
      @(posedge clk); @(negedge clk);
      #1 model_check();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule